// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency of a clock synthesizer from the divider settings a driver would program into it. The caller presents a 32-bit divider-control word, a 16-bit fraction word, a mode bit that picks integer or fractional synthesis, and the reference frequency. It then pulses `start`. The block latches the operands on that edge and extracts the multiplier, pre-divider and post-divider exponent. It builds a 64-bit numerator and a power-of-two-scaled divisor. A restoring divider then retires one quotient bit per clock.

In fractional mode the fraction is a signed two's-complement correction to the multiplier, in units of 1/65536. The divisor gets the same 65536 scale, so the result is in the same unit as the reference. The post-divider exponent does not divide the result again. It shifts the divisor left, so it costs no extra cycles. Settings that cannot describe a real frequency skip the divider and complete at once with an error flag and a zero result.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `freq` is 0.
- R2: The multiplier is `div_word[21:12]`, the pre-divider is `div_word[9:4]` and the exponent is `div_word[2:0]`. Every other bit of `div_word` has no effect on the result.
- R3: With `mode_frac`=0 the result is floor(ref × multiplier / (pre-divider << exponent)), computed without overflow in 64 bits.
- R4: With `mode_frac`=1 the coefficient is multiplier × 65536 + the signed value of `frac_word`. The result is floor(coefficient × ref / ((pre-divider × 65536) << exponent)).
- R5: For a valid setting, `done` is high for exactly one cycle. It rises after the 66th rising edge, counting the start edge as the first: 64 divide steps follow the start edge and one more edge registers the result. `err` is 0 at that point.
- R6: A pre-divider field of zero sets `err`=1 and `freq`=0. `done` then rises after the second rising edge, counting the start edge as the first.
- R7: In fractional mode a negative coefficient gets the same error treatment as R6, with the same timing.
- R8: A `start` that arrives while `busy` is high is ignored. It changes neither the result nor the completion time, and it does not cause a second `done`.
- R9: Operands are sampled only on the edge that accepts `start`. Changing the inputs afterwards does not alter the result.
- R10: `busy` is high from the edge after acceptance until `done` rises. `freq` and `err` hold their values from completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; accepted only while idle |
| mode_frac | input | 1 | 0 = integer synthesis, 1 = fractional synthesis |
| div_word | input | 32 | Divider-control word holding the multiplier, pre-divider and exponent fields |
| frac_word | input | 16 | Signed fraction, used in fractional mode only |
| ref_freq | input | 32 | Reference frequency, in any unit |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed request had an invalid setting |
| freq | output | 64 | Truncated output frequency, same unit as `ref_freq` |

## Verification
The bench drives the extreme operands: the largest multiplier with an all-ones reference, and the largest pre-divider and exponent together with a negative fraction. A divider whose remainder is one bit too narrow, or whose numerator is formed at 32 bits, returns a wrong quotient on exactly these cases. It also checks a zero pre-divider and a zero multiplier with a negative fraction. A design without the error path would either divide by zero or return a huge wrapped value. Junk in the unused bits of the control word catches a wrong field slice. A second start during a run, together with inputs changed straight after acceptance, exposes a design that restarts or samples its operands late. In every case the observed latency is measured exactly, so an off-by-one in the step counter shows up as a wrong cycle count.

// File: rtl/pll_freq_pkg.sv
package pll_freq_pkg;
  // Field layout of the divider-control word (positions decoded by software)
  localparam int MUL_LO = 12;
  localparam int MUL_W  = 10;
  localparam int PRE_LO = 4;
  localparam int PRE_W  = 6;
  localparam int EXP_LO = 0;
  localparam int EXP_W  = 3;
  localparam int FRAC_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_BAD
  } calc_state_t;
endpackage

// File: rtl/pfc_operand.sv
module pfc_operand
  import pll_freq_pkg::*;
#(
  parameter int REF_W = 32,
  parameter int RES_W = 64,
  parameter int CTL_W = 32
) (
  input  logic              mode_frac,
  input  logic [CTL_W-1:0]  div_word,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [REF_W-1:0]  ref_freq,
  output logic [RES_W-1:0]  num,
  output logic [RES_W-1:0]  den,
  output logic              bad
);
  localparam int COEF_W = MUL_W + FRAC_W + 1;
  localparam int SH_W   = $clog2(FRAC_W + (1 << EXP_W));

  logic [MUL_W-1:0]  mul;
  logic [PRE_W-1:0]  pre;
  logic [EXP_W-1:0]  expo;
  logic [COEF_W-1:0] coef_frac;
  logic [COEF_W-1:0] coef;
  logic [SH_W-1:0]   shamt;

  assign mul  = div_word[MUL_LO +: MUL_W];
  assign pre  = div_word[PRE_LO +: PRE_W];
  assign expo = div_word[EXP_LO +: EXP_W];

  // multiplier scaled by 2^16 plus sign-extended fraction
  assign coef_frac = {1'b0, mul, {FRAC_W{1'b0}}}
                   + {{(COEF_W-FRAC_W){frac_word[FRAC_W-1]}}, frac_word};

  always_comb begin
    if (mode_frac) begin
      coef  = coef_frac;
      shamt = SH_W'(FRAC_W) + SH_W'(expo);
    end else begin
      coef  = COEF_W'(mul);
      shamt = SH_W'(expo);
    end
    num = RES_W'(coef) * RES_W'(ref_freq);
    den = RES_W'(pre) << shamt;
    bad = (pre == '0) || (mode_frac && coef_frac[COEF_W-1]);
  end
endmodule

// File: rtl/pfc_divider.sv
module pfc_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     q_r;
  logic [W-1:0]     d_r;
  logic [W-1:0]     r_r;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [W:0]       trial;
  logic [W:0]       diff;
  logic             ge;

  assign trial = {r_r, q_r[W-1]};
  assign diff  = trial - {1'b0, d_r};
  assign ge    = !diff[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
      d_r <= '0;
      r_r <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        q_r <= num;
        d_r <= den;
        r_r <= '0;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        q_r <= {q_r[W-2:0], ge};
        r_r <= ge ? diff[W-1:0] : trial[W-1:0];
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(W-1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;

  // partial remainder stays below the divisor during a run (R3, R4)
  assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> (r_r < d_r));
  // completion flag is a single-cycle pulse (R5)
  assert_fin_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
  // a load is never issued on top of a running division (R8)
  assert_no_reload_R8: assert property (@(posedge clk) disable iff (rst)
    run |-> !load);
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_freq_pkg::*;
#(
  parameter int REF_W = 32,
  parameter int RES_W = 64,
  parameter int CTL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_frac,
  input  logic [CTL_W-1:0]  div_word,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [REF_W-1:0]  ref_freq,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [RES_W-1:0]  freq
);
  calc_state_t      state;
  logic [RES_W-1:0] op_num;
  logic [RES_W-1:0] op_den;
  logic             op_bad;
  logic [RES_W-1:0] div_quo;
  logic             div_fin;
  logic             accept;
  logic             div_load;

  pfc_operand #(.REF_W(REF_W), .RES_W(RES_W), .CTL_W(CTL_W)) u_operand (
    .mode_frac (mode_frac),
    .div_word  (div_word),
    .frac_word (frac_word),
    .ref_freq  (ref_freq),
    .num       (op_num),
    .den       (op_den),
    .bad       (op_bad)
  );

  assign accept   = start && (state == ST_IDLE);
  assign div_load = accept && !op_bad;

  pfc_divider #(.W(RES_W)) u_divider (
    .clk  (clk),
    .rst  (rst),
    .load (div_load),
    .num  (op_num),
    .den  (op_den),
    .quo  (div_quo),
    .fin  (div_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      freq  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) state <= op_bad ? ST_BAD : ST_DIV;
        ST_DIV: if (div_fin) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= 1'b0;
          freq  <= div_quo;
        end
        ST_BAD: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          err   <= 1'b1;
          freq  <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // done is a one-cycle pulse (R5)
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // completion only ever ends a busy period (R10)
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // an error completion always reports zero (R6)
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (freq == '0));
  // busy only rises because a start was presented (R8)
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // results hold between completions (R10)
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(freq) && $stable(err)));
endmodule

// File: tb/tb_pll_freq_calc.sv
module tb_pll_freq_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_frac = 1'b0;
  logic [31:0] div_word = '0;
  logic [15:0] frac_word = '0;
  logic [31:0] ref_freq = '0;
  logic        busy, done, err;
  logic [63:0] freq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam int LAT_OK  = 66;
  localparam int LAT_BAD = 2;

  always #2 clk = ~clk;  // 250 MHz

  pll_freq_calc dut (
    .clk(clk), .rst(rst), .start(start), .mode_frac(mode_frac),
    .div_word(div_word), .frac_word(frac_word), .ref_freq(ref_freq),
    .busy(busy), .done(done), .err(err), .freq(freq)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic void model(input bit md, input logic [31:0] dw, input logic [15:0] fw,
                                input logic [31:0] rf, output logic [63:0] q, output bit e);
    longint unsigned m = longint'(dw[21:12]);
    longint unsigned p = longint'(dw[9:4]);
    int unsigned     s = dw[2:0];
    longint          c;
    longint unsigned dn;
    c = md ? (longint'(m) * 65536 + longint'($signed(fw))) : longint'(m);
    if (p == 0 || c < 0) begin
      e = 1'b1;
      q = '0;
    end else begin
      e  = 1'b0;
      dn = md ? ((p * 65536) << s) : (p << s);
      q  = (longint'(c) * longint'(rf)) / dn;
    end
  endfunction

  task automatic launch(input bit md, input logic [31:0] dw, input logic [15:0] fw,
                        input logic [31:0] rf);
    @(negedge clk);
    start = 1'b1; mode_frac = md; div_word = dw; frac_word = fw; ref_freq = rf;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_check(input string req, input bit md, input logic [31:0] dw,
                           input logic [15:0] fw, input logic [31:0] rf);
    logic [63:0] eq;
    bit ee;
    int lat;
    model(md, dw, fw, rf, eq, ee);
    launch(md, dw, fw, rf);
    wait_done(lat);
    chk({req, " result"}, freq, eq);
    chk({req, " err"}, 64'(err), 64'(ee));
    chk({req, " latency"}, 64'(lat), 64'(ee ? LAT_BAD : LAT_OK));
    @(negedge clk);
    chk("R5 done one cycle", 64'(done), 64'd0);
    chk("R10 result held", freq, eq);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] eq, eq2;
    bit ee;
    int lat;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 err", 64'(err), 0);
    chk("R1 freq", freq, 0);

    // R3 integer table-style settings
    run_check("R3 int 24M m225 p3 s0", 1'b0, {10'd0, 10'd225, 2'd0, 6'd3, 1'b0, 3'd0}, 16'h0, 32'd24_000_000);
    run_check("R3 int 24M m350 p3 s2", 1'b0, {10'd0, 10'd350, 2'd0, 6'd3, 1'b0, 3'd2}, 16'h0, 32'd24_000_000);
    run_check("R3 int max m all-ones ref", 1'b0, {10'd0, 10'd1023, 2'd0, 6'd1, 1'b0, 3'd0}, 16'h0, 32'hFFFF_FFFF);
    // R4 fractional settings
    run_check("R4 frac 24M m262 p2 s3 k9437", 1'b1, {10'd0, 10'd262, 2'd0, 6'd2, 1'b0, 3'd3}, 16'd9437, 32'd24_000_000);
    run_check("R4 frac 24M m361 p3 s3 k17511", 1'b1, {10'd0, 10'd361, 2'd0, 6'd3, 1'b0, 3'd3}, 16'd17511, 32'd24_000_000);
    run_check("R4 frac negative k big divisor", 1'b1, {10'd0, 10'd1, 2'd0, 6'd63, 1'b0, 3'd7}, 16'h8000, 32'hFFFF_FFFF);
    run_check("R4 frac max coef", 1'b1, {10'd0, 10'd1023, 2'd0, 6'd1, 1'b0, 3'd0}, 16'h7FFF, 32'hFFFF_FFFF);
    // R2 junk in unused bits must not matter
    model(1'b0, {10'd0, 10'd300, 2'd0, 6'd3, 1'b0, 3'd1}, 16'h0, 32'd24_000_000, eq, ee);
    launch(1'b0, {10'h3FF, 10'd300, 2'b11, 6'd3, 1'b1, 3'd1}, 16'hFFFF, 32'd24_000_000);
    wait_done(lat);
    chk("R2 unused control bits ignored", freq, eq);
    // R6 zero pre-divider, R7 negative coefficient
    run_check("R6 pre-divider zero int", 1'b0, {10'd0, 10'd200, 2'd0, 6'd0, 1'b0, 3'd1}, 16'h0, 32'd24_000_000);
    run_check("R6 pre-divider zero frac", 1'b1, {10'd0, 10'd200, 2'd0, 6'd0, 1'b0, 3'd1}, 16'd5, 32'd24_000_000);
    run_check("R7 negative coefficient", 1'b1, {10'd0, 10'd0, 2'd0, 6'd2, 1'b0, 3'd0}, 16'hFFFF, 32'd24_000_000);
    run_check("R3 recovery after error", 1'b0, {10'd0, 10'd250, 2'd0, 6'd2, 1'b0, 3'd2}, 16'h0, 32'd25_000_000);

    // R8 and R9: restart attempt while busy, inputs changed after acceptance
    model(1'b1, {10'd0, 10'd198, 2'd0, 6'd2, 1'b0, 3'd2}, 16'd100, 32'd27_000_000, eq, ee);
    launch(1'b1, {10'd0, 10'd198, 2'd0, 6'd2, 1'b0, 3'd2}, 16'd100, 32'd27_000_000);
    chk("R10 busy after accept", 64'(busy), 1);
    div_word = {10'd0, 10'd5, 2'd0, 6'd7, 1'b0, 3'd1};
    ref_freq = 32'd1;
    frac_word = 16'h1234;
    mode_frac = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    div_word = 32'h0;  // would be an error if accepted
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 operands captured at accept", freq, eq);
    chk("R8 ignored start no error", 64'(err), 0);
    chk("R8 latency unchanged", 64'(lat), LAT_OK);
    chk("R10 busy low at done", 64'(busy), 0);
    begin
      int extra = 0;
      repeat (80) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      chk("R8 no second completion", 64'(extra), 0);
    end

    // Random mix, R3 and R4
    for (int i = 0; i < 60; i++) begin
      bit md = 1'($urandom);
      logic [31:0] dw = $urandom;
      logic [15:0] fw = 16'($urandom);
      logic [31:0] rf = $urandom;
      if (($urandom % 8) != 0 && dw[9:4] == 6'd0) dw[9:4] = 6'd1;
      model(md, dw, fw, rf, eq2, ee);
      launch(md, dw, fw, rf);
      wait_done(lat);
      chk(md ? "R4 random" : "R3 random", freq, eq2);
      chk("R5 random latency", 64'(lat), 64'(ee ? LAT_BAD : LAT_OK));
      chk("R6 random err", 64'(err), 64'(ee));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule